// File: doc/BRIEF.md
# Frame-Pulse Lane Deskew Group

This block lines up a group of byte-wide receive lanes so that their output bytes leave in frame, byte and bit lockstep. Each lane brings its own byte stream, its own frame-pulse strobe and its own enable bit. Every lane owns a small circular buffer. Until a lane sees its frame pulse, it keeps overwriting the first slot of that buffer. Once the pulse arrives, the byte that came with the pulse sits in slot 0 and the lane's write pointer advances by one slot on every clock.

A single controller counts clocks from the earliest pulse in the group. When every participating lane has reported its pulse, the controller starts reading all buffers from slot 0 at one shared read address. From then on, the first output byte of every lane is its own frame byte. If a lane stays silent too long, the group drops into an out-of-sync state and raises an alarm.

A two-bit group-size select chooses how many lanes, counted from lane 0, form the group. A realign strobe restarts the whole procedure. The host asserts realign when a lane returns from out-of-frame to in-frame, or whenever software asks for it.

Top module: `frame_deskew_group`

## Requirements
- R1: After reset, `dout_valid`, `oos_alarm`, every bit of `lane_ok` and every output byte are 0.
- R2: A member lane's first valid output byte is the byte that was on its `din` slice in the clock where its `fp` bit was high. Every valid clock after that, each in-sync lane advances by exactly one input byte, so all member lanes output the same frame position.
- R3: When all member pulses arrive in the same clock, `dout_valid` first reads high 9 clocks after that pulse clock.
- R4: When member pulses are spread so that the last one comes d clocks after the first (d ≤ 17), `dout_valid` first reads high max(9, d+2) clocks after the first pulse.
- R5: If some member lane has not pulsed within 17 clocks after the first member pulse, `oos_alarm` reads high 19 clocks after the first pulse and `dout_valid` never rises. The alarm stays high until realign.
- R6: `grp_sel` picks the group. A value of 0 selects lanes 0–1, 1 selects lanes 0–3, and 2 or 3 selects all lanes. Lanes outside the group have pulses that do not matter, and their output bytes stay 0.
- R7: A lane whose `lane_en` bit is 0 is left out of the alignment: it need not pulse, its output byte is 0, and the other lanes align as usual.
- R8: A lane that took part in the last alignment can be disabled and re-enabled during run. Its output is 0 while it is disabled, and it comes back in step with the others without a realign. A lane that did not take part in the last alignment keeps a 0 output after being enabled, until the next realign.
- R9: A `realign` high for one clock forces `dout_valid` and `oos_alarm` low from the next clock on. It also holds every output byte at 0 until a fresh alignment completes.
- R10: Once `dout_valid` is high, it stays high until a realign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_en | input | LANES | Per-lane enable |
| grp_sel | input | 2 | Group size: 0 = 2 lanes, 1 = 4 lanes, 2/3 = all lanes |
| realign | input | 1 | One-clock strobe restarting alignment |
| fp | input | LANES | Per-lane frame pulse |
| din | input | LANES*DW | Lane input bytes, lane i at bits i*DW +: DW |
| dout | output | LANES*DW | Aligned output bytes, same packing |
| dout_valid | output | 1 | Group output valid |
| oos_alarm | output | 1 | Out-of-sync alarm |
| lane_ok | output | LANES | Lane is enabled, in the group and was aligned |

## Verification
The hardest situations to reach are the edges of the skew window. A spread of exactly 17 clocks must still align, with the read start pushed out to 19 clocks. A spread of 18 must trip the alarm instead. Reaching both needs exact per-lane pulse timing. The bench therefore gives every lane a private byte stream whose value encodes its distance from that lane's own pulse, and schedules each pulse at a chosen skew after a realign. Checking that a lane rejoins in step after being disabled mid-run uses the same streams, with enable changes placed after the read start.

// File: rtl/fdg_pkg.sv
// Package: shared types for the frame-pulse deskew group.
package fdg_pkg;
    // Controller phases: idle until a pulse, collecting pulses, reading, alarm.
    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_RUN     = 2'd2,
        ST_OOS     = 2'd3
    } align_state_e;
endpackage

// File: rtl/fdg_lane_buf.sv
// Module: fdg_lane_buf
// One lane's circular buffer. The lane writes every clock. Before its frame
// pulse it writes slot 0; the pulse byte lands in slot 0 and the pointer then
// advances by one slot per clock. Reads use the shared address from the
// controller.
// Assumes: the controller raises 'capture' only while pulses are collected,
// and DEPTH is larger than the worst distance between write and read.
module fdg_lane_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          capture,
    input  logic          fp,
    input  logic [DW-1:0] din,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] dout,
    output logic          seen
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;

    // Store the incoming byte at the current write slot.
    always_ff @(posedge clk) begin
        mem[wptr] <= din;
    end

    // Hold the pointer at 0 until the pulse, then advance once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr <= '0;
        end else if (seen) begin
            wptr <= wptr + 1'b1;
        end else if (capture && fp) begin
            wptr <= AW'(1);
        end else begin
            wptr <= '0;
        end
    end

    // Remember that this lane reported its pulse during collection.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen <= 1'b0;
        end else if (capture && fp) begin
            seen <= 1'b1;
        end
    end

    // Registered read port driven by the shared read address.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            dout <= '0;
        end else if (rd_en) begin
            dout <= mem[raddr];
        end
    end
endmodule

// File: rtl/fdg_ctrl.sv
// Module: fdg_ctrl
// Shared read controller. It counts clocks from the first member pulse. It
// starts the common read once every member lane has pulsed and the minimum
// latency has passed, or raises out-of-sync at the timeout.
// Assumes: all_seen reflects registered per-lane flags, so the read starts
// no earlier than the clock after the last pulse.
module fdg_ctrl
    import fdg_pkg::*;
#(
    parameter int LAT     = 9,
    parameter int TIMEOUT = 18,
    parameter int AW      = 5,
    localparam int CW     = $clog2(TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          realign,
    input  logic          any_fp,
    input  logic          all_seen,
    output align_state_e  state,
    output logic          rd_en,
    output logic [AW-1:0] raddr,
    output logic          out_valid
);
    logic [CW-1:0] cnt;
    logic          go;

    // Read may start: all members seen and the minimum wait has elapsed.
    always_comb begin
        go    = (state == ST_COLLECT) && all_seen && (cnt >= CW'(LAT - 1));
        rd_en = go || (state == ST_RUN);
    end

    // Phase sequencing and the clock count since the first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || realign) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else begin
            case (state)
                ST_WAIT: if (any_fp) begin
                    state <= ST_COLLECT;
                    cnt   <= CW'(1);
                end
                ST_COLLECT: begin
                    if (go) begin
                        state <= ST_RUN;
                    end else if (cnt == CW'(TIMEOUT)) begin
                        state <= ST_OOS;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // Common read address: zero outside run, one step per read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr <= '0;
        end else if (rd_en && !realign) begin
            raddr <= raddr + 1'b1;
        end else if (state != ST_RUN) begin
            raddr <= '0;
        end
    end

    // Output valid follows the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n || realign) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= rd_en;
        end
    end
endmodule

// File: rtl/frame_deskew_group.sv
// Module: frame_deskew_group
// Aligns up to LANES byte lanes on their frame pulses. Lanes outside the
// selected group or with a cleared enable are left out of the alignment and
// output zero.
// Assumes: DEPTH > TIMEOUT + 1, so the earliest lane is never overwritten
// before it is read.
module frame_deskew_group
    import fdg_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int DW      = 8,
    parameter int DEPTH   = 32,
    parameter int LAT     = 9,
    parameter int TIMEOUT = 18,
    localparam int AW     = $clog2(DEPTH),
    localparam int GW     = $clog2(LANES) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    lane_en,
    input  logic [1:0]          grp_sel,
    input  logic                realign,
    input  logic [LANES-1:0]    fp,
    input  logic [LANES*DW-1:0] din,
    output logic [LANES*DW-1:0] dout,
    output logic                dout_valid,
    output logic                oos_alarm,
    output logic [LANES-1:0]    lane_ok
);
    align_state_e     state;
    logic [GW-1:0]    grp_size;
    logic [LANES-1:0] member;
    logic [LANES-1:0] seen;
    logic             capture;
    logic             rd_en;
    logic [AW-1:0]    raddr;

    // Decode the group-size select into a lane count.
    always_comb begin
        case (grp_sel)
            2'd0:    grp_size = GW'(2);
            2'd1:    grp_size = GW'(4);
            default: grp_size = GW'(LANES);
        endcase
    end

    // Pulses are collected while idle or while gathering the group.
    assign capture   = (state == ST_WAIT) || (state == ST_COLLECT);
    assign oos_alarm = (state == ST_OOS);

    fdg_ctrl #(
        .LAT     (LAT),
        .TIMEOUT (TIMEOUT),
        .AW      (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .realign   (realign),
        .any_fp    (|(fp & member)),
        .all_seen  (&(seen | ~member)),
        .state     (state),
        .rd_en     (rd_en),
        .raddr     (raddr),
        .out_valid (dout_valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW-1:0] buf_q;

        // Lane participates when enabled and inside the selected group.
        assign member[g] = lane_en[g] && (GW'(g) < grp_size);

        fdg_lane_buf #(
            .DW    (DW),
            .DEPTH (DEPTH)
        ) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (realign),
            .capture (capture),
            .fp      (fp[g] && member[g]),
            .din     (din[g*DW +: DW]),
            .rd_en   (rd_en),
            .raddr   (raddr),
            .dout    (buf_q),
            .seen    (seen[g])
        );

        // Pass data only for members that were aligned in the last pass.
        assign lane_ok[g]         = dout_valid && member[g] && seen[g];
        assign dout[g*DW +: DW]   = lane_ok[g] ? buf_q : '0;
    end
endmodule

// File: rtl/fdg_checker.sv
// Module: fdg_checker
// Protocol properties of the deskew group, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module fdg_checker (
    input logic clk,
    input logic rst_n,
    input logic realign,
    input logic dout_valid,
    input logic oos_alarm
);
    AST_ALARM_BLOCKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        oos_alarm |-> !dout_valid);                                  // R5
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        oos_alarm && !realign |=> oos_alarm);                        // R5
    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid && !realign |=> dout_valid);                      // R10
    AST_REALIGN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !dout_valid && !oos_alarm);                      // R9
    AST_VALID_NOT_AFTER_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> !$past(oos_alarm));                    // R5
endmodule

bind frame_deskew_group fdg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .realign    (realign),
    .dout_valid (dout_valid),
    .oos_alarm  (oos_alarm)
);

// File: tb/frame_deskew_group_test.sv
// Directed bench for frame_deskew_group: one task per scenario.
module frame_deskew_group_test;
    localparam int LANES = 8;
    localparam int DW    = 8;
    localparam int BASE  = 3;
    localparam int NCYC  = 46;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LANES-1:0]    lane_en = '0;
    logic [1:0]          grp_sel = 2'd2;
    logic                realign = 1'b0;
    logic [LANES-1:0]    fp = '0;
    logic [LANES*DW-1:0] din = '0;
    logic [LANES*DW-1:0] dout;
    logic                dout_valid;
    logic                oos_alarm;
    logic [LANES-1:0]    lane_ok;

    int checks = 0;
    int errors = 0;
    int skew [LANES];

    always #4 clk = ~clk;   // 125 MHz

    frame_deskew_group uut (
        .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .grp_sel(grp_sel),
        .realign(realign), .fp(fp), .din(din), .dout(dout),
        .dout_valid(dout_valid), .oos_alarm(oos_alarm), .lane_ok(lane_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_valid == 1'b0, "R1 valid", int'(dout_valid), 0);
        chk(oos_alarm == 1'b0, "R1 alarm", int'(oos_alarm), 0);
        chk(lane_ok == '0, "R1 lane_ok", int'(lane_ok), 0);
        chk(dout == '0, "R1 dout", int'(dout[31:0]), 0);
    endtask

    // Generic alignment scenario: realign at t=0, then per-lane pulses at
    // BASE+skew. Optional mid-run toggle of one lane and late enable of another.
    task automatic run_align(input logic [7:0] en, input logic [1:0] gs,
                             input int tog_lane, input int tog_off, input int tog_on,
                             input int late_lane, input int late_on, input string req);
        int gsz, first, last, d, vstart, astart;
        bit tmo;
        logic [7:0] grp, mem_set, en_now, en_prev;
        int p [LANES];
        gsz = (gs == 2'd0) ? 2 : (gs == 2'd1) ? 4 : 8;
        first = 1000; last = -1;
        for (int i = 0; i < LANES; i++) begin
            grp[i] = (i < gsz);
            mem_set[i] = en[i] && grp[i];
            p[i] = -(BASE + skew[i]);
            if (mem_set[i]) begin
                if (BASE + skew[i] < first) first = BASE + skew[i];
                if (BASE + skew[i] > last)  last  = BASE + skew[i];
            end
        end
        d = last - first;
        tmo = (d >= 18);
        vstart = first + ((d + 2 > 9) ? d + 2 : 9);
        astart = first + 19;
        en_prev = en;
        grp_sel = gs;
        for (int t = 0; t < NCYC; t++) begin
            @(negedge clk);
            if (t >= 1) begin
                bit ev, ea;
                ev = !tmo && (t >= vstart);
                ea = tmo && (t >= astart);
                chk(dout_valid == ev, {req, " valid"}, int'(dout_valid), int'(ev));
                chk(oos_alarm == ea, {req, " alarm"}, int'(oos_alarm), int'(ea));
                for (int i = 0; i < LANES; i++) begin
                    logic [7:0] eb;
                    bit on;
                    on = ev && mem_set[i] && en_prev[i];
                    eb = on ? 8'(64 + t - vstart) : 8'd0;
                    chk(dout[i*DW +: DW] == eb, {req, " byte"},
                        int'(dout[i*DW +: DW]), int'(eb));
                end
            end
            en_now = en;
            if (tog_lane >= 0 && t >= tog_off && t < tog_on) en_now[tog_lane] = 1'b0;
            if (late_lane >= 0 && t >= late_on) en_now[late_lane] = 1'b1;
            lane_en = en_now;
            en_prev = en_now;
            realign = (t == 0);
            for (int i = 0; i < LANES; i++) begin
                fp[i] = (p[i] == 0);
                din[i*DW +: DW] = 8'(p[i] + 64);
                p[i]++;
            end
        end
        fp = '0;
    endtask

    // R2 R3: all pulses in the same clock
    task automatic t_together();
        skew = '{0, 0, 0, 0, 0, 0, 0, 0};
        run_align(8'hFF, 2'd2, -1, 0, 0, -1, 0, "R3 R2 together");
    endtask

    // R4: small spread keeps 9, large spread stretches, 17 is the edge
    task automatic t_spread();
        skew = '{0, 2, 5, 1, 3, 0, 4, 2};
        run_align(8'hFF, 2'd2, -1, 0, 0, -1, 0, "R4 spread5");
        skew = '{3, 0, 12, 7, 1, 9, 4, 5};
        run_align(8'hFF, 2'd3, -1, 0, 0, -1, 0, "R4 spread12");
        skew = '{0, 17, 3, 3, 3, 3, 3, 3};
        run_align(8'hFF, 2'd2, -1, 0, 0, -1, 0, "R4 spread17");
    endtask

    // R5: one lane too late raises the alarm; then R9 clears it
    task automatic t_timeout();
        skew = '{0, 0, 0, 18, 0, 0, 0, 0};
        run_align(8'hFF, 2'd2, -1, 0, 0, -1, 0, "R5 timeout");
        skew = '{0, 0, 0, 0, 0, 0, 0, 0};
        run_align(8'hFF, 2'd2, -1, 0, 0, -1, 0, "R9 after alarm");
    endtask

    // R6: small groups ignore outer lanes, even with wild skews
    task automatic t_groups();
        skew = '{1, 4, 30, 25, 0, 0, 0, 0};
        run_align(8'hFF, 2'd0, -1, 0, 0, -1, 0, "R6 group2");
        skew = '{2, 0, 6, 1, 40, 33, 21, 19};
        run_align(8'hFF, 2'd1, -1, 0, 0, -1, 0, "R6 group4");
    endtask

    // R7: disabled lane never pulses; R8: toggle and late enable
    task automatic t_enable();
        skew = '{0, 1, 2, 3, 4, 40, 1, 0};
        run_align(8'hDF, 2'd2, -1, 0, 0, -1, 0, "R7 disabled");
        skew = '{0, 1, 2, 0, 1, 2, 0, 1};
        run_align(8'hBF, 2'd2, 1, 16, 22, 6, 20, "R8 rejoin");
    endtask

    initial begin
        t_reset();
        t_together();
        t_spread();
        t_timeout();
        t_groups();
        t_enable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule